// File: doc/BRIEF.md
# Interleaved I/Q Transmit Data Deinterleaver

This block sits at the entry of a transmit datapath. Its input is a single sample bus on which I and Q words alternate, with a framing strobe that shows where each pair begins. From this stream it rebuilds complete I/Q pairs. Each pair appears on registered outputs for one cycle, with a valid pulse, as signed two's complement words ready for the filters further down the chain.

Static control inputs set the behaviour. They choose which strobe level opens a pair, whether I or Q travels first, and whether input words are offset binary or two's complement. They also choose between one word per clock and two words per clock. In the two-word mode the words arrive already captured on the rising and falling edges. A path enable gates the whole function. A sticky framing-error flag records broken pairing. The block samples the control inputs only when no half-built pair is pending, so a setting never changes in the middle of a pair.

Top module: `iq_deinterleaver`

## Requirements
- R1: When `cfg_single_rate`=1, one word is taken per enabled clock from `din_rise`/`mark_rise`. With `cfg_mark_hi_first`=0, a word with mark 0 opens a pair and a following word with mark 1 closes it. The closed pair shows on `pair_i`/`pair_q` with `pair_vld`=1 for one cycle, right after the clock edge that took the closing word.
- R2: With `cfg_mark_hi_first`=1 the roles swap: mark 1 opens a pair and mark 0 closes it.
- R3: With `cfg_i_first`=1 the opening word is I and the closing word is Q. With 0 the opening word is Q and the closing word is I.
- R4: With `cfg_offset_bin`=1 each word is converted by inverting its MSB (0x800 becomes 0x000 and 0x7FF becomes 0xFFF at 12 bits). With 0 words pass unchanged.
- R5: When `cfg_single_rate`=0, two words are taken per clock. The `din_rise` word comes before the `din_fall` word in sequence. A pair may span two clocks, and at most one pair is produced per clock.
- R6: While `path_en`=0 no pair is produced. Any half-built pair is discarded, so a later closing word does not complete it.
- R7: An opening word that arrives while a pair is already open drops the stale word, restarts the pair on the new word, and sets `frame_err`.
- R8: A closing word that arrives with no pair open is dropped, produces no pair, and sets `frame_err`.
- R9: Control inputs take effect only when no pair is open. A pair opened under one setting completes under that same setting, even if the inputs change before its closing word.
- R10: A high `rst` at a clock edge clears any open pair, `frame_err` and `pair_vld`.
- R11: Once set, `frame_err` stays at 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| path_en | input | 1 | Enables word intake and pair output |
| cfg_single_rate | input | 1 | 1: one word per clock; 0: two words per clock |
| cfg_mark_hi_first | input | 1 | Strobe level that opens a pair |
| cfg_i_first | input | 1 | 1: I then Q; 0: Q then I |
| cfg_offset_bin | input | 1 | 1: input words are offset binary |
| din_rise | input | W | Word captured on the rising edge (the only word in single-rate mode) |
| mark_rise | input | 1 | Framing strobe for `din_rise` |
| din_fall | input | W | Word captured on the falling edge (double-rate mode only) |
| mark_fall | input | 1 | Framing strobe for `din_fall` |
| pair_vld | output | 1 | One-cycle pulse for each completed pair |
| pair_i | output | W | I word of the pair, two's complement |
| pair_q | output | W | Q word of the pair, two's complement |
| frame_err | output | 1 | Sticky framing-error flag |

## Verification
Some rules can be checked on every cycle, and the assertions cover these. The framing-error flag never falls outside reset, and every framing fault raises it. A disabled path yields no pair. Reset clears the outputs. The active setting stays frozen while a pair is open. The word values can only be shown by the scoreboard scenarios. These include the strobe polarity, the pair order, the MSB conversion, the order of rise and fall words, pairs that span clocks in double-rate mode, and a setting change in the middle of a pair that completes with the old order.

// File: rtl/iqd_pkg.sv
package iqd_pkg;
  localparam int LANES = 2;

  typedef struct packed {
    logic single_rate;
    logic mark_hi_first;
    logic i_first;
    logic offset_bin;
  } iqd_cfg_t;
endpackage

// File: rtl/iqd_phase_step.sv
module iqd_phase_step #(
  parameter int W = 12
) (
  input  logic         in_held,
  input  logic [W-1:0] in_word,
  input  logic         word_vld,
  input  logic [W-1:0] word,
  input  logic         word_mark,
  input  logic         mark_hi_first,
  input  logic         offset_bin,
  output logic         out_held,
  output logic [W-1:0] out_word,
  output logic         fire,
  output logic [W-1:0] first_w,
  output logic [W-1:0] second_w,
  output logic         err_evt
);
  function automatic logic [W-1:0] to_twos(input logic [W-1:0] w, input logic offs);
    return offs ? {~w[W-1], w[W-2:0]} : w;
  endfunction

  logic [W-1:0] conv;
  logic         is_open;

  assign conv    = to_twos(word, offset_bin);
  assign is_open = (word_mark == mark_hi_first);
  assign first_w  = in_word;
  assign second_w = conv;

  always_comb begin
    out_held = in_held;
    out_word = in_word;
    fire     = 1'b0;
    err_evt  = 1'b0;
    if (word_vld) begin
      if (is_open) begin
        err_evt  = in_held;
        out_held = 1'b1;
        out_word = conv;
      end else if (in_held) begin
        fire     = 1'b1;
        out_held = 1'b0;
      end else begin
        err_evt  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iqd_cfg_hold.sv
module iqd_cfg_hold (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  iqd_pkg::iqd_cfg_t cfg_in,
  output iqd_pkg::iqd_cfg_t cfg_act
);
  always_ff @(posedge clk) begin
    if (rst || load) cfg_act <= cfg_in;
  end
endmodule

// File: rtl/iqd_pair_out.sv
module iqd_pair_out #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [W-1:0] first_w,
  input  logic [W-1:0] second_w,
  input  logic         i_first,
  input  logic         err_evt,
  output logic         pair_vld,
  output logic [W-1:0] pair_i,
  output logic [W-1:0] pair_q,
  output logic         frame_err
);
  function automatic logic [2*W-1:0] order_iq(input logic [W-1:0] a,
                                              input logic [W-1:0] b,
                                              input logic ifirst);
    return ifirst ? {a, b} : {b, a};
  endfunction

  logic [2*W-1:0] iq;
  assign iq = order_iq(first_w, second_w, i_first);

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_vld  <= 1'b0;
      pair_i    <= '0;
      pair_q    <= '0;
      frame_err <= 1'b0;
    end else begin
      pair_vld <= fire;
      if (fire) begin
        pair_i <= iq[2*W-1:W];
        pair_q <= iq[W-1:0];
      end
      if (err_evt) frame_err <= 1'b1;
    end
  end
endmodule

// File: rtl/iq_deinterleaver.sv
module iq_deinterleaver #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         path_en,
  input  logic         cfg_single_rate,
  input  logic         cfg_mark_hi_first,
  input  logic         cfg_i_first,
  input  logic         cfg_offset_bin,
  input  logic [W-1:0] din_rise,
  input  logic         mark_rise,
  input  logic [W-1:0] din_fall,
  input  logic         mark_fall,
  output logic         pair_vld,
  output logic [W-1:0] pair_i,
  output logic [W-1:0] pair_q,
  output logic         frame_err
);
  import iqd_pkg::*;

  iqd_cfg_t cfg_in, cfg_act;
  logic     held_q, held_d;
  logic [W-1:0] word_q, word_d;

  logic [W-1:0] lane_word [LANES];
  logic         lane_mark [LANES];
  logic         held_c    [LANES+1];
  logic [W-1:0] word_c    [LANES+1];
  logic         fire_l    [LANES];
  logic         err_l     [LANES];
  logic [W-1:0] first_l   [LANES];
  logic [W-1:0] second_l  [LANES];

  logic         fire_any, err_any;
  logic [W-1:0] sel_first, sel_second;

  assign cfg_in = '{single_rate:   cfg_single_rate,
                    mark_hi_first: cfg_mark_hi_first,
                    i_first:       cfg_i_first,
                    offset_bin:    cfg_offset_bin};

  assign lane_word[0] = din_rise;
  assign lane_mark[0] = mark_rise;
  assign lane_word[1] = din_fall;
  assign lane_mark[1] = mark_fall;

  assign held_c[0] = held_q;
  assign word_c[0] = word_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_vld;
    assign lane_vld = path_en && ((l == 0) || !cfg_act.single_rate);
    iqd_phase_step #(.W(W)) u_step (
      .in_held       (held_c[l]),
      .in_word       (word_c[l]),
      .word_vld      (lane_vld),
      .word          (lane_word[l]),
      .word_mark     (lane_mark[l]),
      .mark_hi_first (cfg_act.mark_hi_first),
      .offset_bin    (cfg_act.offset_bin),
      .out_held      (held_c[l+1]),
      .out_word      (word_c[l+1]),
      .fire          (fire_l[l]),
      .first_w       (first_l[l]),
      .second_w      (second_l[l]),
      .err_evt       (err_l[l])
    );
  end

  always_comb begin
    fire_any   = 1'b0;
    err_any    = 1'b0;
    sel_first  = first_l[0];
    sel_second = second_l[0];
    for (int l = 0; l < LANES; l++) begin
      err_any = err_any | err_l[l];
      if (fire_l[l]) begin
        fire_any   = 1'b1;
        sel_first  = first_l[l];
        sel_second = second_l[l];
      end
    end
  end

  assign held_d = path_en ? held_c[LANES] : 1'b0;
  assign word_d = word_c[LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q <= 1'b0;
      word_q <= '0;
    end else begin
      held_q <= held_d;
      word_q <= word_d;
    end
  end

  iqd_cfg_hold u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (!held_d),
    .cfg_in  (cfg_in),
    .cfg_act (cfg_act)
  );

  iqd_pair_out #(.W(W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire_any),
    .first_w   (sel_first),
    .second_w  (sel_second),
    .i_first   (cfg_act.i_first),
    .err_evt   (err_any),
    .pair_vld  (pair_vld),
    .pair_i    (pair_i),
    .pair_q    (pair_q),
    .frame_err (frame_err)
  );
endmodule

// File: rtl/iqd_checks.sv
module iqd_checks (
  input logic              clk,
  input logic              rst,
  input logic              path_en,
  input logic              pair_vld,
  input logic              frame_err,
  input logic              err_evt,
  input logic              held_d,
  input iqd_pkg::iqd_cfg_t cfg_act
);
  a_r6_disabled_no_pair: assert property (@(posedge clk) disable iff (rst)
    !path_en |=> !pair_vld);

  a_r7_fault_sets_flag: assert property (@(posedge clk) disable iff (rst)
    err_evt |=> frame_err);

  a_r9_cfg_frozen_open: assert property (@(posedge clk) disable iff (rst)
    held_d |=> $stable(cfg_act));

  a_r10_reset_clears: assert property (@(posedge clk)
    rst |=> (!pair_vld && !frame_err));

  a_r11_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err);
endmodule

bind iq_deinterleaver iqd_checks u_chk (
  .clk       (clk),
  .rst       (rst),
  .path_en   (path_en),
  .pair_vld  (pair_vld),
  .frame_err (frame_err),
  .err_evt   (err_any),
  .held_d    (held_d),
  .cfg_act   (cfg_act)
);

// File: tb/sim_iq_deinterleaver.sv
`timescale 1ns/1ps
module sim_iq_deinterleaver;
  localparam int W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic path_en = 1'b0;
  logic cfg_single_rate = 1'b1, cfg_mark_hi_first = 1'b0, cfg_i_first = 1'b1, cfg_offset_bin = 1'b0;
  logic [W-1:0] din_rise = '0, din_fall = '0;
  logic mark_rise = 1'b0, mark_fall = 1'b0;
  logic pair_vld, frame_err;
  logic [W-1:0] pair_i, pair_q;

  always #2 clk = ~clk;

  iq_deinterleaver #(.W(W)) u0 (
    .clk(clk), .rst(rst), .path_en(path_en),
    .cfg_single_rate(cfg_single_rate), .cfg_mark_hi_first(cfg_mark_hi_first),
    .cfg_i_first(cfg_i_first), .cfg_offset_bin(cfg_offset_bin),
    .din_rise(din_rise), .mark_rise(mark_rise), .din_fall(din_fall), .mark_fall(mark_fall),
    .pair_vld(pair_vld), .pair_i(pair_i), .pair_q(pair_q), .frame_err(frame_err)
  );

  typedef struct {
    logic [W-1:0] i;
    logic [W-1:0] q;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   vectors = 0;
  int   fails   = 0;
  string cur_tag = "R1";

  // reference state kept by the bench
  logic m_held = 1'b0;
  logic [W-1:0] m_hw = '0;
  logic m_err = 1'b0;
  logic m_single = 1'b1, m_pol = 1'b0, m_ifirst = 1'b1, m_offs = 1'b0;

  task automatic m_load_cfg();
    m_single = cfg_single_rate;
    m_pol    = cfg_mark_hi_first;
    m_ifirst = cfg_i_first;
    m_offs   = cfg_offset_bin;
  endtask

  task automatic m_step(input logic [W-1:0] w, input logic mk);
    logic [W-1:0] cw;
    exp_t e;
    cw = w;
    if (m_offs) cw[W-1] = ~w[W-1];
    if (mk == m_pol) begin
      if (m_held) m_err = 1'b1;
      m_held = 1'b1;
      m_hw   = cw;
    end else if (m_held) begin
      e.tag = cur_tag;
      if (m_ifirst) begin e.i = m_hw; e.q = cw; end
      else begin e.i = cw; e.q = m_hw; end
      exp_q.push_back(e);
      m_held = 1'b0;
    end else begin
      m_err = 1'b1;
    end
  endtask

  task automatic cyc(input logic en, input logic [W-1:0] a, input logic ma,
                     input logic [W-1:0] b, input logic mb);
    path_en = en; din_rise = a; mark_rise = ma; din_fall = b; mark_fall = mb;
    if (en) begin
      m_step(a, ma);
      if (!m_single) m_step(b, mb);
    end else begin
      m_held = 1'b0;
    end
    if (!m_held) m_load_cfg();
    @(negedge clk);
  endtask

  task automatic w1(input logic [W-1:0] a, input logic ma);
    cyc(1'b1, a, ma, '0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, '0, 1'b0, '0, 1'b0);
  endtask

  task automatic set_cfg(input logic s, input logic p, input logic i, input logic o);
    cfg_single_rate = s; cfg_mark_hi_first = p; cfg_i_first = i; cfg_offset_bin = o;
    idle(1);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    m_held = 1'b0; m_err = 1'b0;
    m_load_cfg();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic check_bit(input logic act, input logic expv, input string tag);
    vectors++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b", tag, act, expv);
    end
  endtask

  task automatic check_drained(input string tag);
    vectors++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL %s: %0d pairs outstanding, expected 0", tag, exp_q.size());
      exp_q.delete();
    end
  endtask

  // monitor: compares every produced pair with the scoreboard
  always @(negedge clk) begin
    if (!rst && pair_vld) begin
      vectors++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s: unexpected pair I=%h Q=%h, expected none", cur_tag, pair_i, pair_q);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (pair_i !== e.i || pair_q !== e.q) begin
          fails++;
          $display("FAIL %s: got I=%h Q=%h expected I=%h Q=%h", e.tag, pair_i, pair_q, e.i, e.q);
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R10: reset state
    check_bit(pair_vld, 1'b0, "R10 pair_vld after reset");
    check_bit(frame_err, 1'b0, "R10 frame_err after reset");

    // R1: single rate, low opens pair
    cur_tag = "R1";
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0);
    w1(12'h123, 1'b0); w1(12'h456, 1'b1);
    w1(12'hABC, 1'b0); w1(12'h001, 1'b1);
    idle(2); check_drained("R1");

    // R2: high opens pair
    cur_tag = "R2";
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0);
    w1(12'h321, 1'b1); w1(12'h654, 1'b0);
    idle(2); check_drained("R2");

    // R3: Q first
    cur_tag = "R3";
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    w1(12'h111, 1'b0); w1(12'h222, 1'b1);
    idle(2); check_drained("R3");

    // R4: offset binary conversion
    cur_tag = "R4";
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1);
    w1(12'h800, 1'b0); w1(12'h7FF, 1'b1);
    w1(12'h000, 1'b0); w1(12'hFFF, 1'b1);
    idle(2); check_drained("R4");

    // R5: double rate, rise word before fall word
    cur_tag = "R5";
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 12'h0A1, 1'b0, 12'h0B2, 1'b1);
    cyc(1'b1, 12'h0C3, 1'b0, 12'h0D4, 1'b1);
    idle(2); check_drained("R5");
    check_bit(frame_err, 1'b0, "R5 no fault in clean double rate");

    // R6: disabled path discards the open pair
    cur_tag = "R6";
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0);
    w1(12'h5A5, 1'b0);
    cyc(1'b0, 12'h777, 1'b1, '0, 1'b0);
    check_bit(pair_vld, 1'b0, "R6 no pair while disabled");
    w1(12'h135, 1'b0); w1(12'h246, 1'b1);
    idle(2); check_drained("R6");
    check_bit(frame_err, 1'b0, "R6 discarded half pair raises no fault");

    // R7: repeated opening word
    cur_tag = "R7";
    w1(12'h0F0, 1'b0); w1(12'h0E0, 1'b0);
    check_bit(frame_err, 1'b1, "R7 flag set on repeated opener");
    w1(12'h0D0, 1'b1);
    idle(3); check_drained("R7");
    // R11: flag holds
    check_bit(frame_err, 1'b1, "R11 flag sticky");
    do_reset();
    check_bit(frame_err, 1'b0, "R10 reset clears flag");

    // R8: orphan closing word (single rate)
    cur_tag = "R8";
    w1(12'h999, 1'b1);
    check_bit(pair_vld, 1'b0, "R8 orphan gives no pair");
    check_bit(frame_err, 1'b1, "R8 flag set on orphan");
    idle(1); check_drained("R8");
    do_reset();

    // R5: double rate, pairs spanning clocks after an orphan
    cur_tag = "R5";
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0);
    cyc(1'b1, 12'h301, 1'b1, 12'h302, 1'b0);
    cyc(1'b1, 12'h303, 1'b1, 12'h304, 1'b0);
    cyc(1'b1, 12'h305, 1'b1, 12'h306, 1'b0);
    cyc(1'b1, 12'h307, 1'b1, '0, 1'b1);
    idle(2); check_drained("R5 spanning");
    check_bit(frame_err, 1'b1, "R8 orphan in double rate");
    do_reset();

    // R9: setting change while a pair is open
    cur_tag = "R9";
    set_cfg(1'b1, 1'b0, 1'b1, 1'b0);
    w1(12'h401, 1'b0);
    cfg_i_first = 1'b0;
    w1(12'h402, 1'b1);
    w1(12'h403, 1'b0); w1(12'h404, 1'b1);
    idle(2); check_drained("R9");
    check_bit(frame_err, 1'b0, "R9 no fault");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule